// File: doc/BRIEF.md
# Dual-Port RAM with Collision Poisoning

A true dual-port synchronous RAM of 4096 bits, arranged as 256 words of 16 bits. Two ports, A and B, share one clock in this model. Each port has its own enable, write enable, address, write data, read data and invalid flag. A port that writes shows its own write data on its output in the same cycle (write-first). A port that reads returns the stored word one clock after its request.

When both ports write the same address in the same cycle, neither port wins. Each port still shows its own write data. The target word is marked poisoned, and a one-cycle collision pulse is raised. Any later read of a poisoned word, from either port, returns all ones and raises that port's invalid flag. A single write to the word without a conflict stores the data and clears the mark. Reset clears every mark and the outputs, but keeps the stored contents.

The contents start from sixteen 256-bit preload parameters. Word `w` takes bits `[16*(w%16)+15 : 16*(w%16)]` of parameter `w/16`. An unset parameter loads as zeros. A short value is zero-extended.

Top module: `dpram_poison`

## Requirements
- R1: After power-up, word `w` holds bits `[16*(w%16)+15 : 16*(w%16)]` of preload parameter number `w/16` (so parameter 0 covers words 0..15 and parameter 15 covers words 240..255), and a preload value shorter than 256 bits is zero-extended.
- R2: Words covered by a preload parameter that is left at its default read as 16'h0000.
- R3: In a cycle where a port is enabled with write enable high, that port's read data one clock later equals its own write data and its invalid flag is 0. This holds even when the other port writes the same address.
- R4: A read issued after another port's completed write to the same address, with no conflict in the read cycle, returns the newly written value.
- R5: When both ports write one address in the same cycle, `collide` is 1 for exactly the following cycle. The word is then poisoned, and the value held underneath it is port A's write data.
- R6: A read of a poisoned word returns 16'hFFFF with the reading port's invalid flag at 1, on either port. A read of a clean word gives an invalid flag of 0.
- R7: A single write to a poisoned word, without a same-address write on the other port, stores the data and clears the poison, so later reads return the data with the flag at 0.
- R8: If one port writes an address while the other port reads it in the same cycle, the reader gets the contents from before the write, and `collide` stays 0.
- R9: A port with enable low keeps its read data and its invalid flag unchanged.
- R10: While `rst_n` is low, both read data buses, both invalid flags and `collide` are 0. Reset clears all poison marks and leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | 8 | Port A word address |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data |
| a_bad | output | 1 | Port A invalid-data flag |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | 8 | Port B word address |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data |
| b_bad | output | 1 | Port B invalid-data flag |
| collide | output | 1 | One-cycle pulse after a same-address dual write |

## Verification
A poison mark that is lost or set in error stays hidden until some port reads that exact word. It then shows one clock after the read: either all ones with the flag set where data was expected, or stale data where the flag should be set. The bench therefore keeps a small address range in its mixed traffic, so that collisions, repairs and reads of the same words happen within a few cycles of each other. A wrong stored word, or a wrong choice between old data and write-first data, shows on the next read of that address. The bench compares every output on every clock against its model.

// File: rtl/dpram_poison.sv
module dpram_poison #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter logic [255:0] INIT_00 = '0,
  parameter logic [255:0] INIT_01 = '0,
  parameter logic [255:0] INIT_02 = '0,
  parameter logic [255:0] INIT_03 = '0,
  parameter logic [255:0] INIT_04 = '0,
  parameter logic [255:0] INIT_05 = '0,
  parameter logic [255:0] INIT_06 = '0,
  parameter logic [255:0] INIT_07 = '0,
  parameter logic [255:0] INIT_08 = '0,
  parameter logic [255:0] INIT_09 = '0,
  parameter logic [255:0] INIT_0A = '0,
  parameter logic [255:0] INIT_0B = '0,
  parameter logic [255:0] INIT_0C = '0,
  parameter logic [255:0] INIT_0D = '0,
  parameter logic [255:0] INIT_0E = '0,
  parameter logic [255:0] INIT_0F = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_bad,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_bad,
  output logic          collide
);
  localparam int DEPTH = 1 << AW;
  localparam int IMG   = 16 * 256;
  localparam logic [IMG-1:0] IMAGE = {INIT_0F, INIT_0E, INIT_0D, INIT_0C,
                                      INIT_0B, INIT_0A, INIT_09, INIT_08,
                                      INIT_07, INIT_06, INIT_05, INIT_04,
                                      INIT_03, INIT_02, INIT_01, INIT_00};

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] poison;

  initial begin
    for (int w = 0; w < DEPTH; w++)
      mem[w] = ((w + 1) * DW <= IMG) ? IMAGE[w*DW +: DW] : '0;
  end

  wire a_wr  = a_en & a_we;
  wire b_wr  = b_en & b_we;
  wire clash = a_wr & b_wr & (a_addr == b_addr);

  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
    if (b_wr && !clash) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) poison <= '0;
    else if (clash) poison[a_addr] <= 1'b1;
    else begin
      if (a_wr) poison[a_addr] <= 1'b0;
      if (b_wr) poison[b_addr] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rdata <= '0;
      a_bad   <= 1'b0;
      b_rdata <= '0;
      b_bad   <= 1'b0;
      collide <= 1'b0;
    end else begin
      collide <= clash;
      if (a_en) begin
        a_rdata <= a_we ? a_wdata : (poison[a_addr] ? '1 : mem[a_addr]);
        a_bad   <= !a_we && poison[a_addr];
      end
      if (b_en) begin
        b_rdata <= b_we ? b_wdata : (poison[b_addr] ? '1 : mem[b_addr]);
        b_bad   <= !b_we && poison[b_addr];
      end
    end
  end

  p_echo_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_we) |=> (a_rdata == $past(a_wdata) && !a_bad));
  p_echo_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && b_we) |=> (b_rdata == $past(b_wdata) && !b_bad));
  p_dual_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_we && b_en && b_we && a_addr == b_addr) |=> collide);
  p_bad_pattern_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    a_bad |-> a_rdata == '1);
  p_bad_pattern_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    b_bad |-> b_rdata == '1);
  p_rw_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_we && b_en && !b_we && a_addr == b_addr) |=> !collide);
  p_hold_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |=> ($stable(a_rdata) && $stable(a_bad)));
  p_hold_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !b_en |=> ($stable(b_rdata) && $stable(b_bad)));
endmodule

// File: tb/dpram_poison_tb.sv
module dpram_poison_tb;
  localparam logic [255:0] P00 = 256'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
  localparam logic [255:0] P05 = 256'hBEEF_CAFE;
  localparam logic [255:0] P0F = {8{32'h9C3E_71D4}};

  logic clk = 0, rst_n = 0;
  logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [7:0] a_addr = 0, b_addr = 0;
  logic [15:0] a_wdata = 0, b_wdata = 0;
  logic [15:0] a_rdata, b_rdata;
  logic a_bad, b_bad, collide;

  dpram_poison #(.INIT_00(P00), .INIT_05(P05), .INIT_0F(P0F)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_bad(a_bad),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_bad(b_bad),
    .collide(collide));

  always #10 clk = ~clk;

  logic [15:0] m_mem [256];
  bit          m_poi [256];
  logic [15:0] e_a = 0, e_b = 0;
  bit          e_abad = 0, e_bbad = 0, e_col = 0;
  int n_tests = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(string tag);
    n_tests++;
    if (a_rdata !== e_a || a_bad !== e_abad || b_rdata !== e_b || b_bad !== e_bbad || collide !== e_col) begin
      n_fail++;
      $display("FAIL %s: actual a=%h/%0b b=%h/%0b col=%0b expected a=%h/%0b b=%h/%0b col=%0b",
               tag, a_rdata, a_bad, b_rdata, b_bad, collide, e_a, e_abad, e_b, e_bbad, e_col);
    end
  endtask

  task automatic model_edge();
    bit col;
    bit a_w, b_w;
    a_w = a_en && a_we;
    b_w = b_en && b_we;
    col = a_w && b_w && a_addr == b_addr;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_poi[i] = 0;
      e_a = 0; e_b = 0; e_abad = 0; e_bbad = 0; e_col = 0;
      return;
    end
    if (a_en) begin
      if (a_we) begin e_a = a_wdata; e_abad = 0; end
      else begin e_abad = m_poi[a_addr]; e_a = e_abad ? 16'hFFFF : m_mem[a_addr]; end
    end
    if (b_en) begin
      if (b_we) begin e_b = b_wdata; e_bbad = 0; end
      else begin e_bbad = m_poi[b_addr]; e_b = e_bbad ? 16'hFFFF : m_mem[b_addr]; end
    end
    e_col = col;
    if (col) begin
      m_poi[a_addr] = 1;
      m_mem[a_addr] = a_wdata;
    end else begin
      if (a_w) begin m_mem[a_addr] = a_wdata; m_poi[a_addr] = 0; end
      if (b_w) begin m_mem[b_addr] = b_wdata; m_poi[b_addr] = 0; end
    end
  endtask

  task automatic step(bit ae, bit aw, int aa, int ad, bit be, bit bw, int ba, int bd, string tag);
    a_en = ae; a_we = aw; a_addr = 8'(aa); a_wdata = 16'(ad);
    b_en = be; b_we = bw; b_addr = 8'(ba); b_wdata = 16'(bd);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int w = 0; w < 256; w++) begin
      logic [255:0] p;
      p = (w / 16 == 0) ? P00 : (w / 16 == 5) ? P05 : (w / 16 == 15) ? P0F : 256'h0;
      m_mem[w] = p[(w % 16) * 16 +: 16];
      m_poi[w] = 0;
    end
    @(negedge clk);
    step(1, 0, 3, 0, 1, 0, 4, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    rst_n = 1;
    idle("R10");

    for (int i = 0; i < 256; i++) begin
      int p;
      p = i / 16;
      step(1, 0, i, 0, 1, 0, 255 - i, 0, (p == 0 || p == 5 || p == 15 || (15 - p) == 0 || (15 - p) == 5 || (15 - p) == 15) ? "R1" : "R2");
    end

    step(1, 1, 10, 16'h1234, 1, 0, 10, 0, "R8");
    step(0, 0, 0, 0, 1, 0, 10, 0, "R4");
    step(1, 1, 11, 16'h0AAA, 1, 1, 12, 16'h0BBB, "R3");
    step(1, 0, 12, 0, 1, 0, 11, 0, "R4");

    step(1, 1, 20, 16'h1111, 1, 1, 20, 16'h2222, "R5");
    idle("R5");
    step(1, 0, 20, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 0, 20, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 1, 5, 16'h7777, 0, 1, 6, 16'h6666, "R9");
    step(1, 0, 21, 0, 1, 0, 20, 0, "R6");

    step(0, 0, 0, 0, 1, 1, 20, 16'h3C3C, "R7");
    step(1, 0, 20, 0, 1, 0, 20, 0, "R7");

    step(1, 1, 30, 16'h4444, 1, 1, 30, 16'h5555, "R5");
    step(1, 1, 30, 16'h6060, 1, 1, 30, 16'h7070, "R5");
    rst_n = 0;
    step(1, 0, 30, 0, 1, 0, 30, 0, "R10");
    rst_n = 1;
    step(1, 0, 30, 0, 1, 0, 30, 0, "R10");

    for (int k = 0; k < 600; k++)
      step(1'($urandom), 1'($urandom), int'($urandom % 6), int'($urandom % 65536),
           1'($urandom), 1'($urandom), int'($urandom % 6), int'($urandom % 65536), "R6");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule